// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 16K words by 4 bits. The RAM has no output-enable pin. The host issues one read or one write at a time over a valid/ready request port. The block turns each request into the chip-select and write-enable strobe pattern that the RAM needs. For a read, it returns the fetched word with a one-cycle valid pulse.

The RAM drives its data pins whenever it is selected and not writing, so the controller's own data driver has to be switched on and off with care. On a write, write enable falls before chip select, so the RAM never enters a read and never drives the bus. The driver stays off for a gap after the strobes overlap, then carries the data for a set window, and goes off on the same edge that ends the write. Between accesses the RAM is deselected and the driver is off.

Every nanosecond limit is a parameter, together with the clock period. The block rounds each limit up to whole cycles. The read wait adds a configurable margin of cycles on top of the access time.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_cs_n=1, mem_we_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: req_ready is 1 only while no access is in progress. A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 on every cycle of the access that follows.
- R3: On a write, the cycle after acceptance has mem_we_n=0 and mem_cs_n=1. mem_cs_n falls on the next edge, so write enable always leads chip select.
- R4: Once both strobes are low on a write, mem_dq_oe stays 0 for WZ cycles, where WZ = ceil(turn-off ns / clock ns), at least 1.
- R5: After that gap, mem_dq_oe=1 and mem_dq_out carries the accepted write data for DV cycles, where DV = max(ceil(data-setup ns / clock ns), ceil(pulse ns / clock ns) - WZ, 1).
- R6: While chip select is low, mem_addr holds the accepted address and does not change. While mem_dq_oe=1, mem_dq_out does not change. Request inputs that change after acceptance have no effect.
- R7: On a read, the cycle after acceptance starts RD cycles with mem_cs_n=0, mem_we_n=1 and mem_dq_oe=0, where RD = ceil(access ns / clock ns) + margin cycles.
- R8: mem_dq_in is sampled on the edge that ends the last read cycle. That same edge raises mem_cs_n and shows rsp_valid=1 with rsp_rdata equal to the sample, for exactly one cycle.
- R9: When an access ends, mem_cs_n=1, mem_we_n=1 and mem_dq_oe=0 all take effect on the same edge. At least one such deselected cycle separates any two accesses.
- R10: mem_dq_oe=1 only while mem_cs_n=0 and mem_we_n=0, so the controller never drives while the RAM may drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Data for a write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench pairs the controller with a RAM model. The model returns a scrambled word until chip select has been low with write enable high for the full access window, and it flags any cycle where both sides drive the bus. A capture taken one cycle early therefore returns the scrambled word, not the stored one. A driver enabled during the turn-off gap, or a write strobe sequence where chip select leads write enable, is caught cycle by cycle. The sweeps cover the entire address space of a reduced configuration and then rewrite half of it, so a write that lands at the wrong address, or a read that returns stale data, shows up as a mismatch against arithmetic data patterns. The request inputs are scrambled during each access, to catch an address or data register that follows the port instead of holding the accepted value.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WGAP,
        ST_WDRV,
        ST_RACC
    } seq_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int WZC  = 1,
    parameter int DVC  = 2,
    parameter int RDC  = 4,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic          tmr_done,
    output seq_state_e    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture
);
    seq_state_e nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                if (req_we) begin
                    nxt = ST_WSET;
                end else begin
                    nxt      = ST_RACC;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RDC - 1);
                end
            end
            ST_WSET: begin
                nxt      = ST_WGAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(WZC - 1);
            end
            ST_WGAP: if (tmr_done) begin
                nxt      = ST_WDRV;
                tmr_load = 1'b1;
                tmr_val  = CW'(DVC - 1);
            end
            ST_WDRV: if (tmr_done) nxt = ST_IDLE;
            ST_RACC: if (tmr_done) begin
                nxt     = ST_IDLE;
                capture = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state != ST_IDLE));
endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath #(
    parameter int AW = 14,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= dq_in;
            rvalid_q <= capture;
        end
    end

    // R8
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |=> !rvalid_q);
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 4,
    parameter int CLK_NS    = 10,
    parameter int T_WZ_NS   = 8,
    parameter int T_DS_NS   = 12,
    parameter int T_WP_NS   = 20,
    parameter int T_ACC_NS  = 25,
    parameter int SYNC_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WZC  = imax(cdiv(T_WZ_NS, CLK_NS), 1);
    localparam int DVC  = imax(imax(cdiv(T_DS_NS, CLK_NS), cdiv(T_WP_NS, CLK_NS) - WZC), 1);
    localparam int RDC  = imax(cdiv(T_ACC_NS, CLK_NS) + SYNC_CYC, 1);
    localparam int MAXC = imax(imax(WZC, DVC), RDC);
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic          tmr_load, tmr_done, accept, capture;
    logic [CW-1:0] tmr_val;

    sramc_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sramc_seq #(.WZC(WZC), .DVC(DVC), .RDC(RDC), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .tmr_done(tmr_done), .state(state), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .accept(accept), .capture(capture)
    );

    sramc_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture(capture), .dq_in(mem_dq_in),
        .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata),
        .rvalid_q(rsp_valid)
    );

    assign req_ready = (state == ST_IDLE);
    assign mem_cs_n  = !(state inside {ST_WGAP, ST_WDRV, ST_RACC});
    assign mem_we_n  = !(state inside {ST_WSET, ST_WGAP, ST_WDRV});
    assign mem_dq_oe = (state == ST_WDRV);

    // R10
    oe_in_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

    // R3
    we_leads_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_cs_n) && !mem_we_n) |-> $past(!mem_we_n));

    // R4
    oe_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> $past(!mem_cs_n && !mem_we_n));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R8
    rsp_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($rose(mem_cs_n) && mem_we_n));

    // R2
    ready_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;
    localparam int AW    = 8;
    localparam int DW    = 4;
    localparam int CLKNS = 20;
    localparam int WZ    = 1;
    localparam int DV    = 1;
    localparam int RD    = 3;
    localparam int NW    = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] mdl [NW];
    logic [DW-1:0] expv [NW];
    int age = 0;

    always #(CLKNS/2) clk = ~clk;

    async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKNS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    assign mem_dq_in = (!mem_cs_n && mem_we_n && age >= RD) ? mdl[mem_addr] : ~mdl[mem_addr];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && mem_we_n) age <= age + 1; else age <= 0;
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) mdl[mem_addr] <= mem_dq_out;
            if (mem_dq_oe && !mem_cs_n && mem_we_n)
                chk(0, "R10", "driver on while RAM drives", 1, 0);
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        chk(req_ready, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk(!req_ready, "R2", "ready while busy", int'(req_ready), 0);
        chk(!mem_we_n && mem_cs_n && !mem_dq_oe, "R3", "we leads cs",
            int'({mem_cs_n, mem_we_n, mem_dq_oe}), 3'b100);
        for (int i = 0; i < WZ; i++) begin
            @(negedge clk);
            chk(!mem_cs_n && !mem_we_n && !mem_dq_oe, "R4", "gap before drive",
                int'({mem_cs_n, mem_we_n, mem_dq_oe}), 3'b000);
        end
        for (int i = 0; i < DV; i++) begin
            @(negedge clk);
            chk(mem_dq_oe && !mem_cs_n && !mem_we_n && mem_dq_out == d, "R5",
                "drive window data", int'(mem_dq_out), int'(d));
            chk(mem_addr == a, "R6", "address held", int'(mem_addr), int'(a));
        end
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready, "R9", "release together",
            int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready}), 4'b1101);
        expv[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_we = 1'b1;
        for (int i = 0; i < RD; i++) begin
            chk(!mem_cs_n && mem_we_n && !mem_dq_oe && !req_ready, "R7", "read strobes",
                int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready}), 4'b0100);
            chk(mem_addr == a, "R6", "read address held", int'(mem_addr), int'(a));
            chk(!rsp_valid, "R8", "no early response", int'(rsp_valid), 0);
            @(negedge clk);
        end
        chk(rsp_valid && mem_cs_n, "R8", "response with release",
            int'({rsp_valid, mem_cs_n}), 2'b11);
        chk(rsp_rdata == expv[a], "R8", "read data", int'(rsp_rdata), int'(expv[a]));
        @(negedge clk);
        chk(!rsp_valid, "R8", "single pulse", int'(rsp_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid, "R1",
            "reset state", int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid, "R1",
            "after reset", int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);
        for (int a = 0; a < NW; a++) do_write(AW'(a), DW'(a * 7 + 3));
        for (int a = 0; a < NW; a++) do_read(AW'(a));
        for (int a = 1; a < NW; a += 2) do_write(AW'(a), DW'(a ^ (a >> 4) ^ 9));
        for (int a = 0; a < NW; a++) do_read(AW'(a));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule